// File: doc/BRIEF.md
# Multi-Port Condition Register File

This block stores sixteen 32-bit condition registers, each split into eight 4-bit fields, and serves several instruction pipelines at once. It has a set of full-width read ports, four by default and five as a build option, and three full-width write ports. Every write port carries an 8-bit mask with one bit per 4-bit field. A port can therefore replace a whole register, or just the fields it owns, in a single cycle.

Instructions that work on a single 4-bit field do not need ports of their own. A small adapter sits on read port 0 and write port 0. When its select input is high, it takes over that port. It turns a 7-bit field address into a register number and a one-hot lane mask. It places the 4-bit write data into the matching lane, or pulls that lane out of the 32-bit read result.

When two write ports hit the same field of the same register in one cycle, the conflict is settled field by field, and the higher-numbered port wins. Reads are combinational from stored state. Writes land on the rising clock edge.

Top module: `cr_regfile`

## Requirements
- R1: Each read port p returns, combinationally, the full 32-bit content of the register named by its 4-bit address. A write made in the same cycle is not visible on the read port until after the next rising edge.
- R2: On a rising edge, a write port with mask bit i set loads bits 4i+3..4i of its data into bits 4i+3..4i of the addressed register (field 0 is the least significant nibble).
- R3: A field whose mask bit is clear on every write port that addresses its register keeps its value.
- R4: When several write ports enable the same field of the same register in one cycle, the field takes the value from the highest-numbered port among them.
- R5: Different fields of one register written by different ports in the same cycle are all updated in that cycle.
- R6: A synchronous active-high reset clears all sixteen registers to zero.
- R7: A field address is 7 bits, with bits 6..3 selecting the register and bits 2..0 selecting the field. While the field-read select is high, read port 0 reads the register named by that field address, and the 4-bit field output carries the selected field.
- R8: While the field-write select is high, the external inputs of write port 0 are ignored. Port 0 instead writes the 4-bit field data into the addressed field only, gated by the field write enable. This write still loses to a higher-numbered port that writes the same field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rdAddr | input | NUM_RD*4 | Register address per read port, port p at bits 4p+3..4p |
| rdData | output | NUM_RD*32 | Register content per read port, port p at bits 32p+31..32p |
| wrAddr | input | NUM_WR*4 | Register address per write port |
| wrEn | input | NUM_WR*8 | Field write mask per write port, port p at bits 8p+7..8p |
| wrData | input | NUM_WR*32 | Write data per write port |
| fldRdSel | input | 1 | Hands read port 0 to the field adapter |
| fldRdAddr | input | 7 | Field address for a field read |
| fldRdData | output | 4 | Selected field, valid while fldRdSel is high |
| fldWrSel | input | 1 | Hands write port 0 to the field adapter |
| fldWrAddr | input | 7 | Field address for a field write |
| fldWrData | input | 4 | Field write data |
| fldWrEn | input | 1 | Field write enable |

## Verification
A table of directed vectors drives whole-register writes, partial masks, a mask on the top lane only, and an empty mask. It also covers a three-way clash on one field and a same-cycle merge of disjoint fields. Each vector tells apart masking, lane placement and port priority. Random traffic then confines the write addresses to four registers, so that overlapping field writes from all ports happen often. Every read port is compared with a reference array before each edge, which also catches any same-cycle forwarding. Directed adapter tests check lane extraction, lane insertion while port 0's own inputs carry conflicting data, and adapter writes losing to a higher port.

// File: rtl/crf_pkg.sv
package crf_pkg;
  localparam int CR_REGS   = 16;
  localparam int CR_FIELDS = 8;
  localparam int FIELD_W   = 4;
  localparam int CR_W      = CR_FIELDS * FIELD_W;
  localparam int REG_AW    = $clog2(CR_REGS);
  localparam int FLD_IW    = $clog2(CR_FIELDS);
  localparam int FLD_AW    = REG_AW + FLD_IW;
  localparam int MAX_WR    = 4;
  localparam int SRC_W     = $clog2(MAX_WR);

  typedef logic [CR_W-1:0] crWord_t;

  // per register, per field: commit strobe and winning source port
  typedef struct packed {
    logic [CR_REGS-1:0][CR_FIELDS-1:0]            fldWe;
    logic [CR_REGS-1:0][CR_FIELDS-1:0][SRC_W-1:0] fldSrc;
  } wrStrobe_t;
endpackage

// File: rtl/crf_field_adapter.sv
module crf_field_adapter
  import crf_pkg::*;
(
  input  logic              fldRdSel,
  input  logic [FLD_AW-1:0] fldRdAddr,
  output logic [FIELD_W-1:0] fldRdData,
  input  logic              fldWrSel,
  input  logic [FLD_AW-1:0] fldWrAddr,
  input  logic [FIELD_W-1:0] fldWrData,
  input  logic              fldWrEn,
  input  logic [REG_AW-1:0] extRdAddr,
  input  logic [REG_AW-1:0] extWrAddr,
  input  logic [CR_FIELDS-1:0] extWrEn,
  input  crWord_t           extWrData,
  output logic [REG_AW-1:0] portRdAddr,
  input  crWord_t           portRdData,
  output logic [REG_AW-1:0] portWrAddr,
  output logic [CR_FIELDS-1:0] portWrEn,
  output crWord_t           portWrData
);
  logic [FLD_IW-1:0] rdLane;
  logic [FLD_IW-1:0] wrLane;

  assign rdLane = fldRdAddr[FLD_IW-1:0];
  assign wrLane = fldWrAddr[FLD_IW-1:0];

  always_comb begin
    portRdAddr = fldRdSel ? fldRdAddr[FLD_AW-1:FLD_IW] : extRdAddr;
    fldRdData  = FIELD_W'(portRdData >> (int'(rdLane) * FIELD_W));
  end

  always_comb begin
    if (fldWrSel) begin
      portWrAddr = fldWrAddr[FLD_AW-1:FLD_IW];
      portWrData = CR_W'(fldWrData) << (int'(wrLane) * FIELD_W);
      portWrEn   = fldWrEn ? (CR_FIELDS'(1) << wrLane) : '0;
    end else begin
      portWrAddr = extWrAddr;
      portWrData = extWrData;
      portWrEn   = extWrEn;
    end
  end
endmodule

// File: rtl/crf_ctrl.sv
module crf_ctrl
  import crf_pkg::*;
#(
  parameter int NUM_WR = 3
) (
  input  logic [NUM_WR-1:0][REG_AW-1:0]    wrAddr,
  input  logic [NUM_WR-1:0][CR_FIELDS-1:0] wrEn,
  output wrStrobe_t                        strobe
);
  // ascending scan: a later (higher) port overrides an earlier one per field
  always_comb begin
    strobe = '0;
    for (int r = 0; r < CR_REGS; r++) begin
      for (int f = 0; f < CR_FIELDS; f++) begin
        for (int p = 0; p < NUM_WR; p++) begin
          if (wrEn[p][f] && (wrAddr[p] == REG_AW'(r))) begin
            strobe.fldWe[r][f]  = 1'b1;
            strobe.fldSrc[r][f] = SRC_W'(p);
          end
        end
      end
    end
  end
endmodule

// File: rtl/crf_datapath.sv
module crf_datapath
  import crf_pkg::*;
#(
  parameter int NUM_RD = 4,
  parameter int NUM_WR = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  wrStrobe_t                     strobe,
  input  logic [NUM_WR-1:0][CR_W-1:0]   wrData,
  input  logic [NUM_RD-1:0][REG_AW-1:0] rdAddr,
  output logic [NUM_RD-1:0][CR_W-1:0]   rdData,
  output logic [CR_REGS-1:0][CR_W-1:0]  crStore
);
  for (genvar r = 0; r < CR_REGS; r++) begin : g_reg
    for (genvar f = 0; f < CR_FIELDS; f++) begin : g_fld
      logic [FIELD_W-1:0] nextVal;
      always_comb begin
        nextVal = '0;
        for (int p = 0; p < NUM_WR; p++) begin
          if (strobe.fldSrc[r][f] == SRC_W'(p))
            nextVal = wrData[p][f*FIELD_W +: FIELD_W];
        end
      end
      always_ff @(posedge clk) begin
        if (rst)
          crStore[r][f*FIELD_W +: FIELD_W] <= '0;
        else if (strobe.fldWe[r][f])
          crStore[r][f*FIELD_W +: FIELD_W] <= nextVal;
      end
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rdData[p] = crStore[rdAddr[p]];
  end
endmodule

// File: rtl/cr_regfile.sv
module cr_regfile
  import crf_pkg::*;
#(
  parameter int NUM_RD = 4,
  parameter int NUM_WR = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_RD*REG_AW-1:0] rdAddr,
  output logic [NUM_RD*CR_W-1:0]   rdData,
  input  logic [NUM_WR*REG_AW-1:0] wrAddr,
  input  logic [NUM_WR*CR_FIELDS-1:0] wrEn,
  input  logic [NUM_WR*CR_W-1:0]   wrData,
  input  logic                     fldRdSel,
  input  logic [FLD_AW-1:0]        fldRdAddr,
  output logic [FIELD_W-1:0]       fldRdData,
  input  logic                     fldWrSel,
  input  logic [FLD_AW-1:0]        fldWrAddr,
  input  logic [FIELD_W-1:0]       fldWrData,
  input  logic                     fldWrEn
);
  logic [NUM_RD-1:0][REG_AW-1:0]    rdAddrV;
  logic [NUM_RD-1:0][CR_W-1:0]      rdDataV;
  logic [NUM_WR-1:0][REG_AW-1:0]    wrAddrV;
  logic [NUM_WR-1:0][CR_FIELDS-1:0] wrEnV;
  logic [NUM_WR-1:0][CR_W-1:0]      wrDataV;
  logic [CR_REGS-1:0][CR_W-1:0]     crStore;
  wrStrobe_t                        strobe;

  crf_field_adapter adapt_i (
    .fldRdSel   (fldRdSel),
    .fldRdAddr  (fldRdAddr),
    .fldRdData  (fldRdData),
    .fldWrSel   (fldWrSel),
    .fldWrAddr  (fldWrAddr),
    .fldWrData  (fldWrData),
    .fldWrEn    (fldWrEn),
    .extRdAddr  (rdAddr[REG_AW-1:0]),
    .extWrAddr  (wrAddr[REG_AW-1:0]),
    .extWrEn    (wrEn[CR_FIELDS-1:0]),
    .extWrData  (wrData[CR_W-1:0]),
    .portRdAddr (rdAddrV[0]),
    .portRdData (rdDataV[0]),
    .portWrAddr (wrAddrV[0]),
    .portWrEn   (wrEnV[0]),
    .portWrData (wrDataV[0])
  );

  for (genvar p = 1; p < NUM_RD; p++) begin : g_rdIn
    assign rdAddrV[p] = rdAddr[p*REG_AW +: REG_AW];
  end
  for (genvar p = 0; p < NUM_RD; p++) begin : g_rdOut
    assign rdData[p*CR_W +: CR_W] = rdDataV[p];
  end
  for (genvar p = 1; p < NUM_WR; p++) begin : g_wrIn
    assign wrAddrV[p] = wrAddr[p*REG_AW +: REG_AW];
    assign wrEnV[p]   = wrEn[p*CR_FIELDS +: CR_FIELDS];
    assign wrDataV[p] = wrData[p*CR_W +: CR_W];
  end

  crf_ctrl #(.NUM_WR(NUM_WR)) ctrl_i (
    .wrAddr (wrAddrV),
    .wrEn   (wrEnV),
    .strobe (strobe)
  );

  crf_datapath #(.NUM_RD(NUM_RD), .NUM_WR(NUM_WR)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .wrData  (wrDataV),
    .rdAddr  (rdAddrV),
    .rdData  (rdDataV),
    .crStore (crStore)
  );
endmodule

// File: rtl/crf_checker.sv
module crf_checker
  import crf_pkg::*;
#(
  parameter int NUM_WR = 3
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NUM_WR*REG_AW-1:0]    wrAddr,
  input logic [NUM_WR*CR_FIELDS-1:0] wrEn,
  input logic [NUM_WR*CR_W-1:0]      wrData,
  input logic                        fldRdSel,
  input logic [FLD_AW-1:0]           fldRdAddr,
  input logic [FIELD_W-1:0]          fldRdData,
  input logic                        fldWrSel,
  input logic [FLD_AW-1:0]           fldWrAddr,
  input logic                        fldWrEn,
  input logic [CR_REGS-1:0][CR_W-1:0] crStore
);
  localparam int HI = NUM_WR - 1;

  // which register fields any port (with adapter override on port 0) touches
  logic [CR_REGS-1:0][CR_FIELDS-1:0] touched;
  always_comb begin
    touched = '0;
    for (int p = 0; p < NUM_WR; p++) begin
      for (int f = 0; f < CR_FIELDS; f++) begin
        if (p == 0 && fldWrSel) begin
          if (fldWrEn && int'(fldWrAddr[FLD_IW-1:0]) == f)
            touched[fldWrAddr[FLD_AW-1:FLD_IW]][f] = 1'b1;
        end else if (wrEn[p*CR_FIELDS + f]) begin
          touched[wrAddr[p*REG_AW +: REG_AW]][f] = 1'b1;
        end
      end
    end
  end

  // R6: every register reads zero on the cycle after reset
  assert_reset_clear_R6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (crStore == '0));

  // R3: untouched fields hold
  for (genvar r = 0; r < CR_REGS; r++) begin : g_r
    for (genvar f = 0; f < CR_FIELDS; f++) begin : g_f
      assert_untouched_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !touched[r][f] |=> $stable(crStore[r][f*FIELD_W +: FIELD_W]));
    end
  end

  // R4 / R2: the highest port always lands its enabled lanes
  for (genvar f = 0; f < CR_FIELDS; f++) begin : g_hi
    if (HI > 0) begin : g_on
      assert_top_port_wins_R4: assert property (@(posedge clk) disable iff (rst)
        wrEn[HI*CR_FIELDS + f] |=>
          (crStore[$past(wrAddr[HI*REG_AW +: REG_AW])][f*FIELD_W +: FIELD_W]
           == $past(wrData[HI*CR_W + f*FIELD_W +: FIELD_W])));
    end
  end

  // R7: field read output matches the stored field
  assert_field_read_R7: assert property (@(posedge clk) disable iff (rst)
    fldRdSel |-> (fldRdData == FIELD_W'(crStore[fldRdAddr[FLD_AW-1:FLD_IW]]
                   >> (int'(fldRdAddr[FLD_IW-1:0]) * FIELD_W))));
endmodule

bind cr_regfile crf_checker #(.NUM_WR(NUM_WR)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .wrAddr    (wrAddr),
  .wrEn      (wrEn),
  .wrData    (wrData),
  .fldRdSel  (fldRdSel),
  .fldRdAddr (fldRdAddr),
  .fldRdData (fldRdData),
  .fldWrSel  (fldWrSel),
  .fldWrAddr (fldWrAddr),
  .fldWrEn   (fldWrEn),
  .crStore   (crStore)
);

// File: tb/cr_regfile_tb.sv
`timescale 1ns/1ps
module cr_regfile_tb_top;
  localparam int NR = 4;
  localparam int NW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NR*4-1:0]  rdAddr = '0;
  logic [NR*32-1:0] rdData;
  logic [NW*4-1:0]  wrAddr = '0;
  logic [NW*8-1:0]  wrEn = '0;
  logic [NW*32-1:0] wrData = '0;
  logic       fldRdSel = 1'b0;
  logic [6:0] fldRdAddr = '0;
  logic [3:0] fldRdData;
  logic       fldWrSel = 1'b0;
  logic [6:0] fldWrAddr = '0;
  logic [3:0] fldWrData = '0;
  logic       fldWrEn = 1'b0;

  int errors = 0;
  int checks = 0;
  logic [31:0] model [16];

  always #2.5 clk = ~clk;

  cr_regfile #(.NUM_RD(NR), .NUM_WR(NW)) dut_i (.*);

  typedef struct packed {
    logic [23:0] en;
    logic [11:0] addr;
    logic [95:0] data;
    logic [3:0]  chkReg;
    logic [31:0] expVal;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{24'h0000FF, 12'h003, {32'h0, 32'h0, 32'h12345678}, 4'd3, 32'h12345678},
    '{24'h000F00, 12'h030, {32'h0, 32'hAAAAAAAA, 32'h0}, 4'd3, 32'h1234AAAA},
    '{24'hF000FF, 12'h505, {32'h22222222, 32'h0, 32'h11111111}, 4'd5, 32'h22221111},
    '{24'h000C03, 12'h055, {32'h0, 32'h44444444, 32'h33333333}, 4'd5, 32'h22224433},
    '{24'h010101, 12'h777, {32'h3, 32'h2, 32'h1}, 4'd7, 32'h00000003},
    '{24'h000000, 12'h070, {32'h0, 32'hFFFFFFFF, 32'h0}, 4'd7, 32'h00000003},
    '{24'h000080, 12'h00F, {32'h0, 32'h0, 32'h9FFFFFFF}, 4'd15, 32'h90000000}
  };

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference update: ports in ascending order, later port overwrites
  task automatic modelWrite();
    for (int p = 0; p < NW; p++) begin
      for (int f = 0; f < 8; f++) begin
        if (p == 0 && fldWrSel) begin
          if (fldWrEn && int'(fldWrAddr[2:0]) == f)
            model[fldWrAddr[6:3]][f*4 +: 4] = fldWrData;
        end else if (wrEn[p*8 + f]) begin
          model[wrAddr[p*4 +: 4]][f*4 +: 4] = wrData[p*32 + f*4 +: 4];
        end
      end
    end
  endtask

  // reads register r on port (r mod NR); combinational, sampled 1 ns after a negedge
  task automatic readCheck(input int r, input logic [31:0] exp, input string req);
    int p = r % NR;
    @(negedge clk);
    rdAddr[p*4 +: 4] = 4'(r);
    #1;
    check32(req, rdData[p*32 +: 32], exp);
  endtask

  task automatic clearWrites();
    wrEn = '0; fldWrSel = 1'b0; fldWrEn = 1'b0;
  endtask

  task automatic stepWrite();
    modelWrite();
    @(posedge clk);
    @(negedge clk);
    clearWrites();
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    for (int r = 0; r < 16; r++) model[r] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R6: reset state
    for (int r = 0; r < 16; r++) readCheck(r, 32'h0, "R6 reset clear");

    // R1: no forwarding, old value visible while write pending
    @(negedge clk);
    wrAddr[3:0] = 4'd2; wrEn[7:0] = 8'hFF; wrData[31:0] = 32'hCAFEF00D;
    rdAddr[3:0] = 4'd2;
    #1;
    check32("R1 no same-cycle forward", rdData[31:0], 32'h0);
    stepWrite();
    readCheck(2, 32'hCAFEF00D, "R1 read after edge");

    // table of vectors: R2 lanes, R3 mask, R4 priority, R5 merge
    foreach (VECS[i]) begin
      @(negedge clk);
      wrEn = VECS[i].en; wrAddr = VECS[i].addr; wrData = VECS[i].data;
      stepWrite();
      readCheck(int'(VECS[i].chkReg), VECS[i].expVal, "R2/R3/R4/R5 vector");
      check32("R2 model agrees with table", model[VECS[i].chkReg], VECS[i].expVal);
    end

    // R7: field read, external rdAddr0 pointing elsewhere
    @(negedge clk);
    rdAddr[3:0] = 4'd0;
    fldRdSel = 1'b1; fldRdAddr = {4'd15, 3'd7};
    #1;
    check32("R7 field lane 7", {28'h0, fldRdData}, 32'h9);
    check32("R7 port0 full reg", rdData[31:0], 32'h90000000);
    fldRdAddr = {4'd5, 3'd3};
    #1;
    check32("R7 field lane 3", {28'h0, fldRdData}, 32'h4);
    fldRdSel = 1'b0;

    // R8: field write overrides external port 0 inputs
    @(negedge clk);
    wrAddr[3:0] = 4'd9; wrEn[7:0] = 8'hFF; wrData[31:0] = 32'hFFFFFFFF;
    fldWrSel = 1'b1; fldWrEn = 1'b1; fldWrAddr = {4'd9, 3'd2}; fldWrData = 4'hC;
    stepWrite();
    readCheck(9, 32'h00000C00, "R8 field write, ext port0 ignored");

    // R8: field write disabled -> nothing written
    @(negedge clk);
    wrAddr[3:0] = 4'd9; wrEn[7:0] = 8'hFF; wrData[31:0] = 32'hFFFFFFFF;
    fldWrSel = 1'b1; fldWrEn = 1'b0; fldWrAddr = {4'd9, 3'd0}; fldWrData = 4'h1;
    stepWrite();
    readCheck(9, 32'h00000C00, "R8 field write disabled");

    // R8 with R4: higher port beats adapter on the same field
    @(negedge clk);
    fldWrSel = 1'b1; fldWrEn = 1'b1; fldWrAddr = {4'd9, 3'd2}; fldWrData = 4'h5;
    wrAddr[7:4] = 4'd9; wrEn[15:8] = 8'h04; wrData[63:32] = 32'h00000700;
    stepWrite();
    readCheck(9, 32'h00000700, "R8 adapter loses to port 1");

    // random overlapping traffic (R1..R5), addresses confined to regs 0..3
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      for (int p = 0; p < NW; p++) begin
        wrAddr[p*4 +: 4] = 4'($urandom % 4);
        wrEn[p*8 +: 8]   = 8'($urandom);
        wrData[p*32 +: 32] = $urandom;
      end
      for (int p = 0; p < NR; p++) rdAddr[p*4 +: 4] = 4'($urandom % 4);
      #1;
      for (int p = 0; p < NR; p++)
        check32("R1 random read vs model", rdData[p*32 +: 32], model[rdAddr[p*4 +: 4]]);
      modelWrite();
      @(posedge clk);
    end
    @(negedge clk);
    clearWrites();
    for (int r = 0; r < 4; r++) readCheck(r, model[r], "R4/R5 random final");

    // R6: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int r = 0; r < 16; r++) readCheck(r, 32'h0, "R6 reset after traffic");

    finishRun();
  end
endmodule